// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block tracks the coherence state of every line in one processor's direct-mapped cache. Each line has a tag and a two-bit state: Invalid, Shared, Exclusive or Modified. Processor reads and writes are looked up against this array. A hit completes locally. A miss, or a write to a line that is held only Shared, places one transaction on the bus. That transaction is held until the bus reports completion.

At the same time the block watches the transactions that other caches issue: read, read-exclusive, upgrade and flush. It answers each snoop with a shared indication, a dirty flush, or an optional clean cache-to-cache supply, and updates its own copy of the line. When a read fill arrives, the block samples the bus shared signal. The line then lands Exclusive if no other cache holds it, or Shared if one does. A later write to an Exclusive line then needs no bus transaction at all.

Two parameters select variants. The first enables clean supply from an Exclusive holder. The second makes an eviction of an Exclusive line announce itself with a notification transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: Synchronous active-high reset sets every line Invalid and clears every output. After reset, a snoop to any address gets no response.
- R2: A read miss issues bus command 1 (read) in the cycle after the request. When the completion arrives, the line becomes Exclusive if the bus shared input was 0, and Shared if it was 1.
- R3: A read hit, or a write hit on a Modified line, raises cpu_done and cpu_hit in the cycle after the request, with bus command 0 (none).
- R4: A write hit on an Exclusive line completes in the next cycle with no bus transaction. The line becomes Modified.
- R5: A write hit on a Shared line issues command 3 (upgrade) for the request address. When it completes, the line becomes Modified.
- R6: A write miss issues command 2 (read-exclusive). When it completes, the line becomes Modified.
- R7: A snooped read (command 1) that hits a valid line raises snp_shared in the next cycle. A Modified line also raises snp_flush. A Modified or Exclusive line moves to Shared.
- R8: A snooped read-exclusive (2) or upgrade (3) that hits invalidates the line. A Modified line hit by a read-exclusive also raises snp_flush.
- R9: With CLEAN_SUPPLY set, a snooped read or read-exclusive that hits an Exclusive line raises snp_supply. snp_flush and snp_supply are never high together.
- R10: A miss whose victim is Modified first issues command 4 (write-back) with the victim address. An Exclusive victim, with EVICT_NOTIFY set, first issues command 5 (eviction notice). A Shared victim is dropped silently. The fill command for the new address follows the victim's completion.
- R11: When a snoop and a processor request reach the same index in the same cycle, the snoop is applied first. The processor request acts on the state the snoop leaves behind.
- R12: A snoop that misses (the line is Invalid or the tag differs), or any cycle without a snoop, produces no snoop response and leaves the line unchanged.
- R13: A pending bus command and its address stay stable until bus_done is sampled.
- R14: If a snoop invalidates a line while its upgrade is pending, the pending command turns into read-exclusive (2) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request strobe, accepted while the block is idle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address: tag in the upper bits, index in the low IDX_W bits |
| cpu_done | output | 1 | One-cycle pulse when the request completes |
| cpu_hit | output | 1 | With cpu_done: request was a hit |
| bus_cmd | output | 3 | Own bus command: 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back, 5 eviction notice |
| bus_addr | output | ADDR_W | Address of the own bus command |
| bus_done | input | 1 | Completion of the own pending command |
| bus_shared | input | 1 | Shared signal, sampled with bus_done on a read fill |
| snp_valid | input | 1 | A snooped transaction is present |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache writes back its dirty copy |
| snp_supply | output | 1 | This cache supplies a clean copy |

## Verification
Every result is registered exactly once. The bench drives its inputs on the falling edge and samples on the next falling edge, which is one rising edge later. At that point it expects the hit completion, the first bus command of a miss or upgrade, and the snoop response, all in the cycle after the stimulus. A fill, a second command after a victim transaction, or an upgrade completion follows the cycle in which bus_done was driven, and the bench samples one edge after driving it. The pending-command hold is checked on every cycle of a stretched wait. The snoop-over-processor collision is checked by driving both strobes in the same cycle and reading the snoop response and the bus command from the same following cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_RD    = 3'd1,
    BC_RDX   = 3'd2,
    BC_UPGR  = 3'd3,
    BC_FLUSH = 3'd4,
    BC_EVICT = 3'd5
  } bus_cmd_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_WB,
    P_FILL,
    P_UPG
  } proc_st_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_t         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_t         b_st,
  input  logic             tag_we,
  input  logic [TAG_W-1:0] tag_wdata,
  input  logic             a_we,
  input  line_st_t         a_wst,
  input  logic             b_we,
  input  line_st_t         b_wst
);
  localparam int NLINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [NLINES];
  line_st_t         st_q    [NLINES];

  // tag array: one write port, no reset, suitable for distributed RAM
  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[a_idx] <= tag_wdata;
  end

  // state bits: two writers, processor side written last so it wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= ST_I;
    end else begin
      if (b_we) st_q[b_idx] <= b_wst;
      if (a_we) st_q[a_idx] <= a_wst;
    end
  end

  assign a_tag = tag_mem[a_idx];
  assign a_st  = st_q[a_idx];
  assign b_tag = tag_mem[b_idx];
  assign b_st  = st_q[b_idx];
endmodule

// File: rtl/mesi_snoop_rule.sv
module mesi_snoop_rule
  import mesi_pkg::*;
#(
  parameter bit CLEAN_SUPPLY = 1'b1
) (
  input  logic       hit,
  input  logic [2:0] cmd,
  input  line_st_t   st,
  output logic       upd,
  output line_st_t   nxt,
  output logic       shr,
  output logic       flush,
  output logic       supply
);
  logic clean_src;

  always_comb begin
    upd       = 1'b0;
    nxt       = st;
    shr       = 1'b0;
    flush     = 1'b0;
    clean_src = 1'b0;
    if (hit) begin
      case (cmd)
        BC_RD: begin
          shr = 1'b1;
          if (st == ST_M || st == ST_E) begin
            upd       = 1'b1;
            nxt       = ST_S;
            flush     = (st == ST_M);
            clean_src = (st == ST_E);
          end
        end
        BC_RDX: begin
          upd       = 1'b1;
          nxt       = ST_I;
          flush     = (st == ST_M);
          clean_src = (st == ST_E);
        end
        BC_UPGR: begin
          upd = 1'b1;
          nxt = ST_I;
        end
        default: ;
      endcase
    end
  end

  generate
    if (CLEAN_SUPPLY) begin : g_supply
      assign supply = clean_src;
    end else begin : g_nosupply
      assign supply = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int IDX_W        = 4,
  parameter bit CLEAN_SUPPLY = 1'b1,
  parameter bit EVICT_NOTIFY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_done,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic              snp_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;

  proc_st_t          p_st, p_nx;
  logic [ADDR_W-1:0] req_addr;
  logic              req_wr;
  bus_cmd_t          cmd_q, cmd_nx;
  logic [ADDR_W-1:0] baddr_q, baddr_nx;
  logic              done_q, done_nx, hit_q, hit_nx;
  logic              sh_q, fl_q, sup_q;

  logic              busy;
  logic [IDX_W-1:0]  a_idx, s_idx;
  logic [TAG_W-1:0]  a_req_tag, s_tag, a_tag, b_tag;
  line_st_t          a_st, b_st, a_eff;
  logic              a_hit, s_hit;
  logic              s_upd, s_shr, s_fl, s_sup;
  line_st_t          s_nxt;
  logic              pw_en, tag_we;
  line_st_t          pw_st;
  logic              s_same, s_kill;

  assign busy      = (p_st != P_IDLE);
  assign a_idx     = busy ? req_addr[IDX_W-1:0] : cpu_addr[IDX_W-1:0];
  assign a_req_tag = busy ? req_addr[ADDR_W-1:IDX_W] : cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx     = snp_addr[IDX_W-1:0];
  assign s_tag     = snp_addr[ADDR_W-1:IDX_W];

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st),
    .b_idx(s_idx), .b_tag(b_tag), .b_st(b_st),
    .tag_we(tag_we), .tag_wdata(a_req_tag),
    .a_we(pw_en), .a_wst(pw_st),
    .b_we(s_upd), .b_wst(s_nxt)
  );

  assign s_hit = snp_valid && (b_st != ST_I) && (b_tag == s_tag);

  mesi_snoop_rule #(.CLEAN_SUPPLY(CLEAN_SUPPLY)) u_rule (
    .hit(s_hit), .cmd(snp_cmd), .st(b_st),
    .upd(s_upd), .nxt(s_nxt), .shr(s_shr), .flush(s_fl), .supply(s_sup)
  );

  // snoop takes effect before the processor looks at the same index
  assign s_same = s_upd && (s_idx == a_idx);
  assign a_eff  = s_same ? s_nxt : a_st;
  assign a_hit  = (a_eff != ST_I) && (a_tag == a_req_tag);
  assign s_kill = s_same && (s_nxt == ST_I);

  always_comb begin
    p_nx     = p_st;
    cmd_nx   = cmd_q;
    baddr_nx = baddr_q;
    done_nx  = 1'b0;
    hit_nx   = 1'b0;
    pw_en    = 1'b0;
    pw_st    = ST_I;
    tag_we   = 1'b0;
    case (p_st)
      P_IDLE: if (cpu_req) begin
        if (a_hit && cpu_wr && a_eff == ST_S) begin
          cmd_nx   = BC_UPGR;
          baddr_nx = cpu_addr;
          p_nx     = P_UPG;
        end else if (a_hit) begin
          done_nx = 1'b1;
          hit_nx  = 1'b1;
          if (cpu_wr && a_eff == ST_E) begin
            pw_en = 1'b1;
            pw_st = ST_M;
          end
        end else begin
          pw_en = 1'b1;
          pw_st = ST_I;
          if (a_eff == ST_M) begin
            cmd_nx   = BC_FLUSH;
            baddr_nx = {a_tag, a_idx};
            p_nx     = P_WB;
          end else if (a_eff == ST_E && EVICT_NOTIFY) begin
            cmd_nx   = BC_EVICT;
            baddr_nx = {a_tag, a_idx};
            p_nx     = P_WB;
          end else begin
            cmd_nx   = cpu_wr ? BC_RDX : BC_RD;
            baddr_nx = cpu_addr;
            p_nx     = P_FILL;
          end
        end
      end
      P_WB: if (bus_done) begin
        cmd_nx   = req_wr ? BC_RDX : BC_RD;
        baddr_nx = req_addr;
        p_nx     = P_FILL;
      end
      P_FILL: if (bus_done) begin
        tag_we  = 1'b1;
        pw_en   = 1'b1;
        pw_st   = req_wr ? ST_M : (bus_shared ? ST_S : ST_E);
        cmd_nx  = BC_NONE;
        done_nx = 1'b1;
        p_nx    = P_IDLE;
      end
      P_UPG: if (s_kill) begin
        cmd_nx = BC_RDX;
        p_nx   = P_FILL;
      end else if (bus_done) begin
        pw_en   = 1'b1;
        pw_st   = ST_M;
        cmd_nx  = BC_NONE;
        done_nx = 1'b1;
        hit_nx  = 1'b1;
        p_nx    = P_IDLE;
      end
      default: p_nx = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_st     <= P_IDLE;
      req_addr <= '0;
      req_wr   <= 1'b0;
      cmd_q    <= BC_NONE;
      baddr_q  <= '0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      sh_q     <= 1'b0;
      fl_q     <= 1'b0;
      sup_q    <= 1'b0;
    end else begin
      p_st    <= p_nx;
      cmd_q   <= cmd_nx;
      baddr_q <= baddr_nx;
      done_q  <= done_nx;
      hit_q   <= hit_nx;
      sh_q    <= s_shr;
      fl_q    <= s_fl;
      sup_q   <= s_sup;
      if (!busy && cpu_req) begin
        req_addr <= cpu_addr;
        req_wr   <= cpu_wr;
      end
    end
  end

  assign cpu_done   = done_q;
  assign cpu_hit    = hit_q;
  assign bus_cmd    = cmd_q;
  assign bus_addr   = baddr_q;
  assign snp_shared = sh_q;
  assign snp_flush  = fl_q;
  assign snp_supply = sup_q;

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (cmd_q == BC_NONE && !done_q && !sh_q && !fl_q && !sup_q)); // R1
  AST_DONE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cmd_q == BC_NONE); // R3
  AST_E_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_req && cpu_wr && a_hit && a_eff == ST_E)
      |=> (done_q && hit_q && cmd_q == BC_NONE)); // R4
  AST_S_WRITE_UPG: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_req && cpu_wr && a_hit && a_eff == ST_S)
      |=> (cmd_q == BC_UPGR && !done_q)); // R5
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(fl_q && sup_q)); // R9
  AST_SNP_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !snp_valid |=> !(sh_q || fl_q || sup_q)); // R12
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != BC_NONE && cmd_q != BC_UPGR && !bus_done)
      |=> ($stable(cmd_q) && $stable(baddr_q))); // R13
  AST_UPG_KILL: assert property (@(posedge clk) disable iff (rst)
    (p_st == P_UPG && s_kill) |=> cmd_q == BC_RDX); // R14
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_done, cpu_hit;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_done = 1'b0, bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [2:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_flush, snp_supply;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(4)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_done(bus_done), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_supply(snp_supply)
  );

  // vector: kind(2) 0 rd,1 wr,2 snoop | scmd(3) | addr(12) | fill shared(1) |
  //         exp first cmd(3) | exp flags {shared,flush,supply}(3) | exp hit(1)
  localparam int NV = 18;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 3'd0, 12'h010, 1'b0, 3'd1, 3'b000, 1'b0}, // R2 miss, fills E
    {2'd0, 3'd0, 12'h010, 1'b0, 3'd0, 3'b000, 1'b1}, // R3 read hit
    {2'd1, 3'd0, 12'h010, 1'b0, 3'd0, 3'b000, 1'b1}, // R4 E write silent
    {2'd2, 3'd1, 12'h010, 1'b0, 3'd0, 3'b110, 1'b0}, // R7 M read snoop
    {2'd1, 3'd0, 12'h010, 1'b0, 3'd3, 3'b000, 1'b1}, // R5 S write upgrade
    {2'd2, 3'd2, 12'h010, 1'b0, 3'd0, 3'b010, 1'b0}, // R8 M rdx snoop
    {2'd0, 3'd0, 12'h010, 1'b1, 3'd1, 3'b000, 1'b0}, // R2 miss, fills S
    {2'd2, 3'd1, 12'h010, 1'b0, 3'd0, 3'b100, 1'b0}, // R7 S read snoop
    {2'd2, 3'd3, 12'h010, 1'b0, 3'd0, 3'b000, 1'b0}, // R8 upgrade snoop
    {2'd0, 3'd0, 12'h010, 1'b0, 3'd1, 3'b000, 1'b0}, // R8 line gone, E fill
    {2'd2, 3'd1, 12'h010, 1'b0, 3'd0, 3'b101, 1'b0}, // R9 E read supply
    {2'd2, 3'd1, 12'h110, 1'b0, 3'd0, 3'b000, 1'b0}, // R12 tag mismatch
    {2'd1, 3'd0, 12'h021, 1'b0, 3'd2, 3'b000, 1'b0}, // R6 write miss
    {2'd0, 3'd0, 12'h021, 1'b0, 3'd0, 3'b000, 1'b1}, // R6 now held
    {2'd2, 3'd2, 12'h021, 1'b0, 3'd0, 3'b010, 1'b0}, // R6 was M
    {2'd0, 3'd0, 12'h032, 1'b0, 3'd1, 3'b000, 1'b0}, // R2 E fill
    {2'd2, 3'd2, 12'h032, 1'b0, 3'd0, 3'b001, 1'b0}, // R9 E rdx supply
    {2'd2, 3'd1, 12'h032, 1'b0, 3'd0, 3'b000, 1'b0}  // R12 invalid line
  };

  function automatic string vtag(int i);
    case (i)
      0, 6, 15: return "R2";
      1:        return "R3";
      2:        return "R4";
      3, 7:     return "R7";
      4:        return "R5";
      5, 8, 9:  return "R8";
      10, 16:   return "R9";
      12, 13, 14: return "R6";
      default:  return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input logic shr,
                        output logic [2:0] c1, output logic [AW-1:0] a1,
                        output logic [2:0] c2, output logic [AW-1:0] a2,
                        output logic hit);
    c1 = '0; a1 = '0; c2 = '0; a2 = '0; hit = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    if (!cpu_done) begin
      c1 = bus_cmd; a1 = bus_addr;
      for (int n = 0; n < 4 && !cpu_done; n++) begin
        bus_done = 1'b1; bus_shared = shr;
        @(negedge clk);
        bus_done = 1'b0; bus_shared = 1'b0;
        if (n == 0 && !cpu_done) begin
          c2 = bus_cmd; a2 = bus_addr;
        end
      end
    end
    hit = cpu_done & cpu_hit;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [AW-1:0] a, output logic [2:0] fl);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = '0;
    fl = {snp_shared, snp_flush, snp_supply};
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [2:0] c1, c2, fl;
    logic [AW-1:0] a1, a2;
    logic hit;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1", {bus_cmd, cpu_done, snp_shared, snp_flush, snp_supply}, '0);
    snoop(3'd1, 12'h010, fl);
    check("R1", fl, 3'b000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24:23] == 2'd2) begin
        snoop(VEC[i][22:20], VEC[i][19:8], fl);
        check(vtag(i), fl, VEC[i][3:1]);
      end else begin
        cpu_op(VEC[i][23], VEC[i][19:8], VEC[i][7], c1, a1, c2, a2, hit);
        check(vtag(i), {c1, hit}, {VEC[i][6:4], VEC[i][0]});
      end
    end

    // R10 victim handling on index 5
    cpu_op(1'b1, 12'h045, 1'b0, c1, a1, c2, a2, hit);
    check("R6", c1, 3'd2);
    cpu_op(1'b0, 12'h145, 1'b0, c1, a1, c2, a2, hit);
    check("R10", {c1, a1}, {3'd4, 12'h045});
    check("R10", {c2, a2}, {3'd1, 12'h145});
    cpu_op(1'b0, 12'h245, 1'b1, c1, a1, c2, a2, hit);
    check("R10", {c1, a1}, {3'd5, 12'h145});
    check("R10", {c2, a2}, {3'd1, 12'h245});
    cpu_op(1'b0, 12'h345, 1'b0, c1, a1, c2, a2, hit);
    check("R10", {c1, a1, c2}, {3'd1, 12'h345, 3'd0});
    snoop(3'd1, 12'h245, fl);
    check("R10", fl, 3'b000);

    // R11 snoop and write to the same Exclusive line in one cycle
    cpu_op(1'b0, 12'h056, 1'b0, c1, a1, c2, a2, hit);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 12'h056;
    snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = 12'h056;
    @(negedge clk);
    cpu_req = 1'b0; snp_valid = 1'b0; snp_cmd = '0;
    check("R11", {snp_shared, snp_supply, cpu_done, bus_cmd}, {1'b1, 1'b1, 1'b0, 3'd3});
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    check("R11", {cpu_done, cpu_hit}, 2'b11);
    snoop(3'd1, 12'h056, fl);
    check("R11", fl, 3'b110);

    // R13 command held across a stretched wait
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 12'h078;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R13", {bus_cmd, bus_addr}, {3'd1, 12'h078});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R13", {bus_cmd, bus_addr, cpu_done}, {3'd1, 12'h078, 1'b0});
    end
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    check("R13", {cpu_done, bus_cmd}, {1'b1, 3'd0});

    // R14 pending upgrade overtaken by a remote read-exclusive
    cpu_op(1'b0, 12'h067, 1'b1, c1, a1, c2, a2, hit);
    @(negedge clk);
    cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 12'h067;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R5", bus_cmd, 3'd3);
    snp_valid = 1'b1; snp_cmd = 3'd2; snp_addr = 12'h067;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = '0;
    check("R14", {bus_cmd, bus_addr, snp_flush}, {3'd2, 12'h067, 1'b0});
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    check("R14", cpu_done, 1'b1);
    snoop(3'd1, 12'h067, fl);
    check("R14", fl, 3'b110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule